// File: doc/BRIEF.md
# Three-Channel Auto-Reload Down-Counter Timer

This peripheral holds three identical timer channels behind one synchronous register port. Every channel counts a 32-bit value down by one on each tick of its selected count clock, taken from a shared free-running prescaler. Counting only happens while the channel's bit in a common run register is set. When a tick arrives with the counter already at zero, the counter takes the channel's reload value and keeps going. The period is therefore the reload value plus one tick.

Each underflow sets a sticky flag in the channel's control word. While that flag is set and the channel's interrupt enable is on, the channel's interrupt line stays high. Software clears the flag by writing a zero to it. If a new underflow happens in the same cycle as that clearing write, the flag stays set, so no event is lost. Software can load a first-period value directly into the counter before starting it. Every register can be read back at any time.

Top module: `tmr_unit`

## Requirements
- R1: After reset every counter, reload value, control word and run bit is zero, and all interrupt outputs are low.
- R2: Address 0 holds the run bits in [2:0]. Channel n uses address 1+3n for its reload value, 2+3n for its counter and 3+3n for its control word. The control word has the count-clock select in [2:0], the interrupt enable in [3] and the underflow flag in [4]. Reads return current contents with unused bits at zero, and unmapped addresses read zero.
- R3: While a channel's run bit is 0, its counter holds its value.
- R4: The prescaler counts up freely from reset. Select codes 0, 1, 2 and 3 give one tick every 4, 16, 64 and 256 clocks, each tick coming at the edge where the low 2, 4, 6 or 8 prescaler bits are all ones. A tick on a running channel whose counter is non-zero decrements the counter by one.
- R5: A tick on a running channel whose counter is zero loads the reload value and sets the flag, so the repeat period is reload+1 ticks.
- R6: A channel's interrupt output is high exactly while its flag and its enable are both 1.
- R7: A control write with bit 4 at 0 clears the flag. A write with bit 4 at 1 leaves the flag unchanged, and software can never set it.
- R8: When an underflow and a clearing control write fall in the same cycle, the flag ends set.
- R9: Select codes 4 to 7 produce no ticks, so the counter holds.
- R10: A counter write takes effect at the next edge. It overrides any count or reload in that cycle, and the written value is used for the first period.
- R11: Channels are independent: writes and ticks of one never change the state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 3 | Level interrupt per channel |

## Verification
Directed sequences cover four cases: a held counter with its run bit off, a short reload period with the interrupt enabled, a clearing write aligned to the exact tick of an underflow, and the disabled select codes. Each case separates one behaviour, such as holding versus counting, reload versus plain decrement, or clear versus set priority. A long constrained-random phase mixes writes to all eleven addresses with the channels running at different rates. A cycle model in the bench compares every read and every interrupt line against the design. This exposes interactions such as counter writes that coincide with underflows, and crosstalk between channels.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCH_DEF   = 3;
    localparam int CNT_W_DEF = 32;
    localparam int AW        = 4;
    localparam int NDIV      = 4;
    localparam int PRE_W     = 2 * NDIV;
    localparam int SEL_W     = 3;

    localparam int ADDR_RUN  = 0;
    localparam int CH_STRIDE = 3;
    localparam int OFF_RLD   = 0;
    localparam int OFF_CNT   = 1;
    localparam int OFF_CTL   = 2;
    localparam int CTL_W     = SEL_W + 2;

    typedef struct packed {
        logic             flag;
        logic             ie;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    function automatic logic [AW-1:0] ch_addr(input int ch, input int off);
        return AW'(1 + CH_STRIDE * ch + off);
    endfunction

    function automatic logic pick_tick(input logic [SEL_W-1:0] sel,
                                       input logic [NDIV-1:0]  ticks);
        logic t;
        t = 1'b0;
        for (int k = 0; k < NDIV; k++) begin
            if (sel == SEL_W'(k)) t = ticks[k];
        end
        return t;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [NDIV-1:0] ticks
);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    for (genvar k = 0; k < NDIV; k++) begin : g_tap
        assign ticks[k] = &pre_q[2*k+1:0];
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = CNT_W_DEF
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         wr_rld,
    input  logic         wr_cnt,
    input  logic         wr_ctl,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] rld_q,
    output ctl_t         ctl_q
);
    ctl_t wctl;
    logic uflow;

    always_comb begin
        wctl  = ctl_t'(wdata[CTL_W-1:0]);
        uflow = run && tick && !wr_cnt && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_cnt)
                cnt_q <= wdata;
            else if (run && tick)
                cnt_q <= uflow ? rld_q : cnt_q - 1'b1;

            if (wr_rld) rld_q <= wdata;

            if (wr_ctl) begin
                ctl_q.sel <= wctl.sel;
                ctl_q.ie  <= wctl.ie;
            end

            if (uflow)
                ctl_q.flag <= 1'b1;
            else if (wr_ctl && !wctl.flag)
                ctl_q.flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NCH   = NCH_DEF,
    parameter int CNT_W = CNT_W_DEF
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic [NCH-1:0]   irq
);
    logic [NCH-1:0]   run_q;
    logic [NDIV-1:0]  ticks;
    logic [NCH-1:0]   ch_tick;
    logic [CNT_W-1:0] cnt_w [NCH];
    logic [CNT_W-1:0] rld_w [NCH];
    ctl_t             ctl_w [NCH];

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (wr_en && addr == AW'(ADDR_RUN))
            run_q <= wdata[NCH-1:0];
    end

    tmr_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .ticks (ticks)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign ch_tick[c] = pick_tick(ctl_w[c].sel, ticks);
        assign irq[c]     = ctl_w[c].flag && ctl_w[c].ie;

        tmr_channel #(.W(CNT_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .run    (run_q[c]),
            .tick   (ch_tick[c]),
            .wr_rld (wr_en && addr == ch_addr(c, OFF_RLD)),
            .wr_cnt (wr_en && addr == ch_addr(c, OFF_CNT)),
            .wr_ctl (wr_en && addr == ch_addr(c, OFF_CTL)),
            .wdata  (wdata),
            .cnt_q  (cnt_w[c]),
            .rld_q  (rld_w[c]),
            .ctl_q  (ctl_w[c])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(ADDR_RUN)) rdata[NCH-1:0] = run_q;
        for (int c = 0; c < NCH; c++) begin
            if (addr == ch_addr(c, OFF_RLD)) rdata = rld_w[c];
            if (addr == ch_addr(c, OFF_CNT)) rdata = cnt_w[c];
            if (addr == ch_addr(c, OFF_CTL)) rdata[CTL_W-1:0] = ctl_w[c];
        end
    end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
    import tmr_pkg::*;
#(
    parameter int NCH   = NCH_DEF,
    parameter int CNT_W = CNT_W_DEF
)(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [AW-1:0]    addr,
    input logic [CNT_W-1:0] wdata,
    input logic [NCH-1:0]   run,
    input logic [NCH-1:0]   ch_tick,
    input logic [NCH-1:0]   irq,
    input logic [CNT_W-1:0] cnt [NCH],
    input logic [CNT_W-1:0] rld [NCH],
    input ctl_t             ctl [NCH]
);
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        logic wcnt, clr;
        assign wcnt = wr_en && addr == ch_addr(g, OFF_CNT);
        assign clr  = wr_en && addr == ch_addr(g, OFF_CTL) && !wdata[CTL_W-1];

        AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
            (!run[g] && !wcnt) |=> cnt[g] == $past(cnt[g])); // R3
        AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
            (run[g] && ch_tick[g] && !wcnt && cnt[g] != '0) |=> cnt[g] == $past(cnt[g]) - 1'b1); // R4
        AST_RELOAD_UF: assert property (@(posedge clk) disable iff (rst)
            (run[g] && ch_tick[g] && !wcnt && cnt[g] == '0) |=> (cnt[g] == $past(rld[g]) && ctl[g].flag)); // R5
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (ctl[g].flag && !clr) |=> ctl[g].flag); // R7
        AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> (ctl[g].flag && ctl[g].ie)); // R6
        AST_NO_TICK_HIGH: assert property (@(posedge clk) disable iff (rst)
            (ctl[g].sel >= SEL_W'(NDIV)) |-> !ch_tick[g]); // R9
    end
endmodule

bind tmr_unit tmr_unit_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .run     (run_q),
    .ch_tick (ch_tick),
    .irq     (irq),
    .cnt     (cnt_w),
    .rld     (rld_w),
    .ctl     (ctl_w)
);

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
    localparam int CLK_P = 10;
    localparam int NCH   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    tmr_unit uut (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata), .irq(irq));

    always #(CLK_P/2) clk = ~clk;

    // reference state built from the requirements
    logic [31:0] m_cnt [NCH];
    logic [31:0] m_rld [NCH];
    logic [2:0]  m_sel [NCH];
    logic        m_ie  [NCH];
    logic        m_flg [NCH];
    logic [2:0]  m_run;
    logic [7:0]  m_pc;

    function automatic logic m_tick(input logic [2:0] sel, input logic [7:0] pc);
        logic [7:0] mask;
        if (sel > 3) return 1'b0;                       // R9
        mask = 8'((32'd1 << (2 * sel + 2)) - 1);        // R4
        return (pc & mask) == mask;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        int c, o;
        if (a == 0) return {29'd0, m_run};
        if (a > 9) return 32'd0;
        c = (a - 1) / 3;
        o = (a - 1) % 3;
        if (o == 0) return m_rld[c];
        if (o == 1) return m_cnt[c];
        return {27'd0, m_flg[c], m_ie[c], m_sel[c]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pc <= '0;
            m_run <= '0;
            for (int c = 0; c < NCH; c++) begin
                m_cnt[c] <= '0; m_rld[c] <= '0; m_sel[c] <= '0;
                m_ie[c] <= 1'b0; m_flg[c] <= 1'b0;
            end
        end else begin
            m_pc <= m_pc + 1'b1;
            if (wr_en && addr == 0) m_run <= wdata[2:0];
            for (int c = 0; c < NCH; c++) begin
                automatic int b = 1 + 3 * c;
                automatic logic uf = 1'b0;
                if (wr_en && addr == 4'(b + 1))
                    m_cnt[c] <= wdata;                   // R10
                else if (m_run[c] && m_tick(m_sel[c], m_pc)) begin
                    if (m_cnt[c] == 0) begin
                        m_cnt[c] <= m_rld[c];
                        uf = 1'b1;
                    end else m_cnt[c] <= m_cnt[c] - 1;
                end
                if (wr_en && addr == 4'(b)) m_rld[c] <= wdata;
                if (wr_en && addr == 4'(b + 2)) begin
                    m_sel[c] <= wdata[2:0];
                    m_ie[c]  <= wdata[3];
                end
                if (uf) m_flg[c] <= 1'b1;                // R8
                else if (wr_en && addr == 4'(b + 2) && !wdata[4]) m_flg[c] <= 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at cycle %0d", req, got, exp, cycles);
        end
    endtask

    // one cycle: compare current outputs to the model, then drive new inputs
    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        chk(req, rdata, m_read(addr));
        chk(req, {29'd0, irq}, {29'd0, m_flg[2] & m_ie[2], m_flg[1] & m_ie[1], m_flg[0] & m_ie[0]});
        wr_en = we; addr = a; wdata = d;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, addr, 32'd0, req);
    endtask

    task automatic rd_exp(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        automatic int unsigned seed = $urandom(32'd20417);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: everything clear after reset
        for (int a = 0; a < 10; a++) rd_exp(4'(a), 32'd0, "R1");
        chk("R1", {29'd0, irq}, 32'd0);

        // R2: map, masking, unmapped reads
        step(1'b1, 4'd4, 32'hDEADBEEF, "R2");
        step(1'b1, 4'd9, 32'hFFFFFFFF, "R2");
        step(1'b1, 4'd0, 32'hFFFFFFF8, "R2");
        rd_exp(4'd4, 32'hDEADBEEF, "R2");
        rd_exp(4'd9, 32'h0000000F, "R2");
        rd_exp(4'd0, 32'd0, "R2");
        rd_exp(4'd12, 32'd0, "R2");
        step(1'b1, 4'd9, 32'd0, "R2");
        step(1'b1, 4'd4, 32'd0, "R2");

        // R3: stopped channel holds its value
        step(1'b1, 4'd2, 32'd5, "R3");
        step(1'b1, 4'd3, 32'h0, "R3");
        idle(40, "R3");
        rd_exp(4'd2, 32'd5, "R3");

        // R5/R6/R10: initial value 1, reload 2, interrupt on, fastest rate
        step(1'b1, 4'd1, 32'd2, "R5");
        step(1'b1, 4'd2, 32'd1, "R10");
        step(1'b1, 4'd3, 32'h08, "R6");
        step(1'b1, 4'd0, 32'd1, "R5");
        idle(60, "R5");
        chk("R6", {31'd0, irq[0]}, 32'd1);

        // R7: stop, then write-1 keeps flag, write-0 clears it
        step(1'b1, 4'd0, 32'd0, "R7");
        step(1'b1, 4'd3, 32'h18, "R7");
        rd_exp(4'd3, 32'h18, "R7");
        step(1'b1, 4'd3, 32'h08, "R7");
        rd_exp(4'd3, 32'h08, "R7");
        chk("R6", {31'd0, irq[0]}, 32'd0);

        // R8: clearing write in the very cycle of an underflow
        step(1'b1, 4'd2, 32'd0, "R8");
        step(1'b0, 4'd0, 32'd0, "R8");
        while (m_pc[1:0] != 2'd2) step(1'b0, 4'd0, 32'd0, "R8");
        wr_en = 1'b1; addr = 4'd0; wdata = 32'd1;   // run from this edge, no tick yet
        step(1'b1, 4'd3, 32'h08, "R8");             // this edge ticks: underflow vs clear
        rd_exp(4'd3, 32'h18, "R8");
        step(1'b1, 4'd0, 32'd0, "R8");
        step(1'b1, 4'd3, 32'h00, "R8");

        // R9: disabled select code on channel 1
        step(1'b1, 4'd5, 32'd9, "R9");
        step(1'b1, 4'd6, 32'h05, "R9");
        step(1'b1, 4'd0, 32'd2, "R9");
        idle(300, "R9");
        rd_exp(4'd5, 32'd9, "R9");

        // R4/R11: three channels at different rates
        step(1'b1, 4'd6, 32'h09, "R4");
        step(1'b1, 4'd9, 32'h0B, "R4");
        step(1'b1, 4'd8, 32'd3, "R4");
        step(1'b1, 4'd7, 32'd1, "R4");
        step(1'b1, 4'd3, 32'h08, "R4");
        step(1'b1, 4'd0, 32'd7, "R11");
        idle(1200, "R4");

        // R11 random mix: writes everywhere, compared every cycle
        for (int i = 0; i < 6000; i++) begin
            automatic logic [3:0]  a = 4'($urandom % 11);
            automatic logic        we = ($urandom % 4) == 0;
            automatic logic [31:0] d;
            case (a)
                4'd0: d = $urandom % 8;
                4'd3, 4'd6, 4'd9: d = ($urandom % 32) | (($urandom % 2) << 4);
                default: d = $urandom % 40;
            endcase
            step(we, a, d, "R11");
        end
        idle(2, "R11");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        if (seed == 0) $display("seed");
        $finish;
    end
endmodule